// File: doc/BRIEF.md
# Page-Offset-Indexed L1 Data Cache Lookup

This block is the lookup stage of a level-one data cache. It starts reading its set storage before the virtual address has been translated. With 64-byte lines and 64 sets, the set number sits entirely in address bits [11:6]. Those bits lie inside the 12-bit page offset, so they are the same before and after translation. The block therefore latches the selected set's tags, valid bits and addressed word on the request edge. Meanwhile a separate translation unit looks up the physical page number.

One cycle later the translation answer arrives: a 20-bit physical page number and a fault flag. Only then does the block compare the stored physical tags against it and report hit or miss with the data word. The tag and data storage is held in flops and is either direct-mapped or two-way, chosen by a parameter. A fill port loads a whole line, its tag and its valid bit into a chosen set and way. Miss handling beyond that port is left to the surrounding logic.

Top module: `vipt_lookup`

## Requirements
- R1: The set is selected by virtual address bits [11:6] and the 32-bit word within the 64-byte line by bits [5:2]. Word k occupies `fill_line[32*k +: 32]`, and bits [1:0] have no effect.
- R2: A request is accepted when `req_valid` is high and `fill_valid` is low. `rsp_valid` is high in exactly the cycle after an accepted request and low in every other cycle.
- R3: In the response cycle, `rsp_hit` is high exactly when some way of the selected set is valid and holds a tag equal to `tr_ppn`, and `tr_fault` is low. `rsp_hit` is low whenever `rsp_valid` is low.
- R4: `rsp_data_ok` equals `rsp_hit`. On a hit, `rsp_data` is the addressed word of the lowest-numbered matching way.
- R5: When `tr_fault` is high in the response cycle, `rsp_hit` and `rsp_data_ok` are both low, whatever the stored tags hold.
- R6: When `fill_valid` and `req_valid` are high in the same cycle, the fill is performed and the request is dropped, so no response follows.
- R7: After reset every line is invalid, and every lookup misses until a fill occurs.
- R8: A fill writes the line, the tag and the valid bit into set `fill_set`, way `fill_way`. Other ways and other sets are left unchanged, and a later lookup sees the new contents.
- R9: Virtual address bits [31:12] do not affect the result. Only `tr_ppn` is compared with the stored tag.
- R10: A fill performed during the response cycle does not change that response, because the set contents were captured on the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address of the lookup |
| tr_ppn | input | 20 | Physical page number from translation, one cycle after the request |
| tr_fault | input | 1 | Translation fault, one cycle after the request |
| fill_valid | input | 1 | Write a line this cycle |
| fill_set | input | 6 | Set written by the fill |
| fill_way | input | 1 | Way written by the fill (ignored when direct-mapped) |
| fill_ppn | input | 20 | Physical tag stored with the filled line |
| fill_line | input | 512 | Line data; word k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data_ok | output | 1 | `rsp_data` carries valid data |
| rsp_data | output | 32 | Addressed word on a hit, zero otherwise |

## Verification
The bench fills both ways of one set with different tags and reads each back. A design that ignored the way select, or that let one way's fill disturb the other, would return the wrong word. Requests carry random upper virtual bits and random byte bits. An index or word select taken from the wrong bits would then hit the wrong set or return a neighbouring word.

The bench also issues a request together with a fill, and a design that did not give the fill priority would emit a spurious response. A fill into the same set during the response cycle catches a design that reads the storage late rather than on the request edge. Faulted translations with a matching tag catch a hit that leaks through the fault.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_BITS  = 12;
  localparam int LINE_OFF   = 6;
  localparam int WORD_OFF   = 2;
  localparam int SET_BITS   = PAGE_BITS - LINE_OFF;
  localparam int SETS       = 1 << SET_BITS;
  localparam int WORD_W     = 8 << WORD_OFF;
  localparam int WSEL_BITS  = LINE_OFF - WORD_OFF;
  localparam int LINE_WORDS = 1 << WSEL_BITS;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int PPN_W      = ADDR_W - PAGE_BITS;

  typedef logic [SET_BITS-1:0]  set_t;
  typedef logic [WSEL_BITS-1:0] wsel_t;
  typedef logic [PPN_W-1:0]     ppn_t;
  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [LINE_W-1:0]    line_t;

  // Set index comes only from page-offset bits
  function automatic set_t set_of(input logic [ADDR_W-1:0] va);
    return va[PAGE_BITS-1:LINE_OFF];
  endfunction

  function automatic wsel_t word_of(input logic [ADDR_W-1:0] va);
    return va[LINE_OFF-1:WORD_OFF];
  endfunction

  function automatic word_t pick_word(input line_t line, input wsel_t k);
    return line[k*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/vipt_way.sv
module vipt_way
  import vipt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  set_t  wr_set,
  input  ppn_t  wr_tag,
  input  line_t wr_line,
  input  logic  rd_en,
  input  set_t  rd_set,
  input  wsel_t rd_word,
  output logic  q_valid,
  output ppn_t  q_tag,
  output word_t q_word
);
  line_t            data_q [SETS];
  ppn_t             tag_q  [SETS];
  logic [SETS-1:0]  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[wr_set] <= wr_line;
      tag_q[wr_set]  <= wr_tag;
    end
  end

  // Snapshot of the indexed set, taken on the request edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_word  <= '0;
    end else if (rd_en) begin
      q_valid <= vld_q[rd_set];
      q_tag   <= tag_q[rd_set];
      q_word  <= pick_word(data_q[rd_set], rd_word);
    end
  end
endmodule

// File: rtl/vipt_compare.sv
module vipt_compare
  import vipt_pkg::*;
#(
  parameter int WAYS = 2
) (
  input  logic             pend,
  input  ppn_t             ppn,
  input  logic             fault,
  input  logic [WAYS-1:0]  q_valid,
  input  ppn_t             q_tag  [WAYS],
  input  word_t            q_word [WAYS],
  output logic [WAYS-1:0]  way_hit,
  output logic             hit,
  output word_t            data
);
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      way_hit[w] = pend && !fault && q_valid[w] && (q_tag[w] == ppn);
  end

  // Lowest matching way wins
  always_comb begin
    data = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_hit[w]) data = q_word[w];
  end

  assign hit = |way_hit;
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int WAYS  = 2,
  localparam int WY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [PPN_W-1:0]  tr_ppn,
  input  logic              tr_fault,
  input  logic              fill_valid,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [WY_W-1:0]   fill_way,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [LINE_W-1:0] fill_line,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_data_ok,
  output logic [WORD_W-1:0] rsp_data
);
  // Named internal events
  logic             req_accept;
  logic [WAYS-1:0]  way_wr;
  logic [WAYS-1:0]  way_valid;
  logic [WAYS-1:0]  way_hit;
  ppn_t             way_tag  [WAYS];
  word_t            way_word [WAYS];
  logic             pend_q;
  logic             cmp_hit;
  word_t            cmp_data;
  logic             unused_va;

  assign unused_va  = ^{req_va[ADDR_W-1:PAGE_BITS], req_va[WORD_OFF-1:0]};
  assign req_accept = req_valid && !fill_valid;

  generate
    if (WAYS == 1) begin : g_dm
      logic unused_way;
      assign unused_way = ^fill_way;
      assign way_wr     = fill_valid;
    end else begin : g_assoc
      always_comb begin
        for (int w = 0; w < WAYS; w++)
          way_wr[w] = fill_valid && (fill_way == WY_W'(w));
      end
    end
  endgenerate

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      vipt_way u_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (way_wr[w]),
        .wr_set  (fill_set),
        .wr_tag  (fill_ppn),
        .wr_line (fill_line),
        .rd_en   (req_accept),
        .rd_set  (set_of(req_va)),
        .rd_word (word_of(req_va)),
        .q_valid (way_valid[w]),
        .q_tag   (way_tag[w]),
        .q_word  (way_word[w])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req_accept;
  end

  vipt_compare #(.WAYS(WAYS)) u_cmp (
    .pend    (pend_q),
    .ppn     (tr_ppn),
    .fault   (tr_fault),
    .q_valid (way_valid),
    .q_tag   (way_tag),
    .q_word  (way_word),
    .way_hit (way_hit),
    .hit     (cmp_hit),
    .data    (cmp_data)
  );

  assign rsp_valid   = pend_q;
  assign rsp_hit     = cmp_hit;
  assign rsp_data_ok = cmp_hit;
  assign rsp_data    = cmp_data;
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int WAYS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            fill_valid,
  input logic            tr_fault,
  input logic [WAYS-1:0] way_hit,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_data_ok,
  input logic [31:0]     rsp_data
);
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fill_valid) |=> rsp_valid);
  a_r2_no_rsp_unasked: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !fill_valid) |=> !rsp_valid);
  a_r6_fill_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !rsp_valid);
  a_r3_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && (way_hit != '0));
  a_r5_fault_miss: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fault |-> !rsp_hit && !rsp_data_ok);
  a_r4_ok_tracks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_data_ok == rsp_hit);
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_data == '0);
endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .fill_valid  (fill_valid),
  .tr_fault    (tr_fault),
  .way_hit     (way_hit),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_data_ok (rsp_data_ok),
  .rsp_data    (rsp_data)
);

// File: tb/sim_vipt_lookup.sv
module sim_vipt_lookup;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_va = '0;
  logic [19:0]  tr_ppn = '0;
  logic         tr_fault = 1'b0;
  logic         fill_valid = 1'b0;
  logic [5:0]   fill_set = '0;
  logic [0:0]   fill_way = '0;
  logic [19:0]  fill_ppn = '0;
  logic [511:0] fill_line = '0;
  logic         rsp_valid, rsp_hit, rsp_data_ok;
  logic [31:0]  rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the storage
  logic         m_vld  [64][2];
  logic [19:0]  m_tag  [64][2];
  logic [511:0] m_line [64][2];
  logic [19:0]  pool   [4];

  always #10 clk = ~clk;

  vipt_lookup #(.WAYS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .tr_ppn(tr_ppn), .tr_fault(tr_fault), .fill_valid(fill_valid),
    .fill_set(fill_set), .fill_way(fill_way), .fill_ppn(fill_ppn),
    .fill_line(fill_line), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_data_ok(rsp_data_ok), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] word_in(input logic [511:0] l, input logic [31:0] va);
    int k = int'(va[5:2]);
    return l[32*k +: 32];
  endfunction

  function automatic logic [511:0] rand_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[32*i +: 32] = $urandom;
    return l;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_fill(input int s, input int w, input logic [19:0] t, input logic [511:0] l);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = 6'(s); fill_way = 1'(w); fill_ppn = t; fill_line = l;
    @(negedge clk);
    fill_valid = 1'b0;
    m_vld[s][w] = 1'b1; m_tag[s][w] = t; m_line[s][w] = l;
  endtask

  task automatic do_lookup(input logic [31:0] va, input logic [19:0] ppn, input bit flt, input string rq);
    int s = int'(va[11:6]);
    bit eh = 1'b0;
    logic [31:0] ed = '0;
    for (int w = 1; w >= 0; w--)
      if (!flt && m_vld[s][w] && m_tag[s][w] == ppn) begin eh = 1'b1; ed = word_in(m_line[s][w], va); end
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0; tr_ppn = ppn; tr_fault = flt;
    #2;
    chk(rsp_valid === 1'b1, {rq, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit === eh, {rq, " R3 hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_data_ok === eh, {rq, " R4 data_ok"}, 64'(rsp_data_ok), 64'(eh));
    if (eh) chk(rsp_data === ed, {rq, " R4 data"}, 64'(rsp_data), 64'(ed));
    tr_fault = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] la, lb, lc;
    void'($urandom(32'd2024));
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; m_line[s][w] = '0; end
    for (int i = 0; i < 4; i++) pool[i] = 20'h1000 + 20'(i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 idle after reset", 64'(rsp_valid), 64'd0);

    // R7: empty after reset, even with tag 0
    do_lookup(32'h0000_0040, 20'h0, 1'b0, "R7 empty");
    do_lookup(32'hABCD_E7FC, 20'hABCDE, 1'b0, "R7 empty2");

    // R8: both ways of one set, distinct tags
    la = rand_line(); lb = rand_line();
    do_fill(5, 0, 20'h11111, la);
    do_fill(5, 1, 20'h22222, lb);
    do_lookup({20'h11111, 6'd5, 4'd3, 2'b00}, 20'h11111, 1'b0, "R8 way0");
    do_lookup({20'h22222, 6'd5, 4'd9, 2'b00}, 20'h22222, 1'b0, "R8 way1");
    do_lookup({20'h22222, 6'd6, 4'd9, 2'b00}, 20'h22222, 1'b0, "R8 other set");
    // R1: byte bits ignored, word select by [5:2]
    do_lookup({20'h0, 6'd5, 4'd15, 2'b11}, 20'h11111, 1'b0, "R1 byte bits");
    do_lookup({20'h0, 6'd5, 4'd0, 2'b01}, 20'h22222, 1'b0, "R1 word0");
    // R9: upper virtual bits unrelated to the tag
    do_lookup({20'hFFFFF, 6'd5, 4'd7, 2'b10}, 20'h11111, 1'b0, "R9 va upper");
    do_lookup({20'h11111, 6'd5, 4'd7, 2'b00}, 20'h33333, 1'b0, "R9 ppn mismatch");
    // R5: fault with matching tag
    do_lookup({20'h11111, 6'd5, 4'd2, 2'b00}, 20'h11111, 1'b1, "R5 fault");
    // R4: equal tags in both ways, way 0 wins
    lc = rand_line();
    do_fill(9, 0, 20'h44444, la);
    do_fill(9, 1, 20'h44444, lc);
    do_lookup({20'h0, 6'd9, 4'd4, 2'b00}, 20'h44444, 1'b0, "R4 lowest way");

    // R6: fill and request together
    @(negedge clk);
    lc = rand_line();
    fill_valid = 1'b1; fill_set = 6'd12; fill_way = 1'b1; fill_ppn = 20'h55555; fill_line = lc;
    req_valid = 1'b1; req_va = {20'h0, 6'd12, 6'd0};
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0; tr_ppn = 20'h55555;
    m_vld[12][1] = 1; m_tag[12][1] = 20'h55555; m_line[12][1] = lc;
    #2;
    chk(rsp_valid === 1'b0, "R6 request dropped", 64'(rsp_valid), 64'd0);
    chk(rsp_hit === 1'b0, "R6 no hit", 64'(rsp_hit), 64'd0);
    do_lookup({20'h0, 6'd12, 4'd6, 2'b00}, 20'h55555, 1'b0, "R6 fill landed");

    // R10: fill during the response cycle does not alter the response
    @(negedge clk);
    req_valid = 1'b1; req_va = {20'h0, 6'd5, 4'd1, 2'b00};
    @(negedge clk);
    req_valid = 1'b0; tr_ppn = 20'h11111;
    lc = rand_line();
    fill_valid = 1'b1; fill_set = 6'd5; fill_way = 1'b0; fill_ppn = 20'h66666; fill_line = lc;
    #2;
    chk(rsp_hit === 1'b1, "R10 old hit", 64'(rsp_hit), 64'd1);
    chk(rsp_data === word_in(la, {26'd0, 4'd1, 2'b00}), "R10 old data", 64'(rsp_data), 64'(word_in(la, {26'd0, 4'd1, 2'b00})));
    @(negedge clk);
    fill_valid = 1'b0;
    m_tag[5][0] = 20'h66666; m_line[5][0] = lc;
    do_lookup({20'h0, 6'd5, 4'd1, 2'b00}, 20'h11111, 1'b0, "R10 now replaced");
    do_lookup({20'h0, 6'd5, 4'd1, 2'b00}, 20'h66666, 1'b0, "R10 new tag");

    // Random mix over a few sets and a small tag pool
    for (int i = 0; i < 400; i++) begin
      int s = int'($urandom_range(0, 7)) * 9;
      logic [19:0] t = pool[$urandom_range(0, 3)];
      if ($urandom_range(0, 3) == 0)
        do_fill(s, int'($urandom_range(0, 1)), t, rand_line());
      else
        do_lookup({20'($urandom), 6'(s), 6'($urandom)}, t, ($urandom_range(0, 9) == 0), "R3 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule